// File: doc/BRIEF.md
# Command Bus Parity Checker

This block guards the command/address bus of a registered memory module with an even-parity check. Each clock it captures the address, bank, row-strobe, column-strobe and write-enable lines with the chip selects. One clock later it takes the parity bit that the controller sends for that command. If at least one chip select was low when the command was captured, the block compares the two. A mismatch drives an active-low error flag and a one-cycle suppress strobe, so the downstream command register can discard the bad command.

The bus is sampled on every clock and has no way to stall, so it uses no valid/ready handshake and has no back-pressure. The parity bit always belongs to the command captured on the edge before it. Chip-select lines do not enter the parity sum. Clock-enable and termination lines are not wired to the block at all.

The error flag stays low for a fixed number of cycles after each detected error. A new error that arrives while the flag is low starts the count again. The suppress strobe gives one pulse for each bad command, so bad commands on back-to-back cycles can still be counted one by one.

Top module: `cmd_parity_check`

## Requirements
- R1: The checked word is `ca_addr`, `ca_bank`, `ca_ras_n`, `ca_cas_n` and `ca_we_n`, together with `par_in`. A qualified command is in error when this set holds an odd number of ones.
- R2: The `par_in` value sampled on the clock edge after a command's capture edge is the one paired with that command. The `par_in` value on the capture edge itself is not used for that command.
- R3: A command is qualified only when at least one bit of `cs_n` is 0 on its capture edge.
- R4: A command captured while every bit of `cs_n` is 1 never raises `cmd_drop` and never pulls `err_n` low, whatever its parity.
- R5: Which chip select is low, and how many are low, has no effect on the parity result.
- R6: For a command in error, `cmd_drop` is high for exactly the one cycle that follows the edge on which its `par_in` is sampled.
- R7: `err_n` goes low in the same cycle as `cmd_drop` and stays low for PULSE_LEN cycles (2 by default). A further error in that window restarts the count from the cycle of the new `cmd_drop`.
- R8: While `rst_n` is low, `err_n` is 1 and `cmd_drop` is 0. Reset also clears the captured command, so a `par_in` mismatch on the first edge after reset flags nothing.
- R9: Bad commands on consecutive cycles each give their own `cmd_drop` pulse, and `err_n` stays low through the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ca_addr | input | ADDR_W | Address lines (included in the parity sum) |
| ca_bank | input | BANK_W | Bank lines (included in the parity sum) |
| ca_ras_n | input | 1 | Row strobe (included in the parity sum) |
| ca_cas_n | input | 1 | Column strobe (included in the parity sum) |
| ca_we_n | input | 1 | Write enable (included in the parity sum) |
| cs_n | input | CS_W | Active-low chip selects (qualify the check, not part of the sum) |
| par_in | input | 1 | Parity bit for the command captured one edge earlier |
| err_n | output | 1 | Active-low parity error flag, stretched over PULSE_LEN cycles |
| cmd_drop | output | 1 | One-cycle strobe telling the downstream register to discard the command |

## Verification
The hardest situation to reach is a parity bit that lands on a cycle when its own command was deselected, while the command on the wire at that moment is selected with a different parity. Only the one-cycle skew separates right from wrong here. To reach it, the stimulus sweeps every data word against every chip-select pattern. It runs this sweep twice, with opposite parity-bit patterns, so every qualified and unqualified command is followed by both parity values. Directed runs add a parity bit that is correct on the capture edge but wrong one edge later, a run of errors on consecutive cycles, and a reset that lands while an error pulse is still active.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  // Captured view of one command: its parity and whether a chip select qualified it.
  typedef struct packed {
    logic odd;
    logic qual;
  } cpc_stage_t;

  localparam cpc_stage_t CPC_STAGE_IDLE = '{odd: 1'b0, qual: 1'b0};
endpackage

// File: rtl/cpc_parity_fold.sv
module cpc_parity_fold #(
  parameter int W = 8
) (
  input  logic [W-1:0] bits,
  output logic         odd
);
  logic [W:0] chain;

  assign chain[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_fold
    assign chain[i+1] = chain[i] ^ bits[i];
  end

  assign odd = chain[W];
endmodule

// File: rtl/cpc_capture.sv
module cpc_capture #(
  parameter int CS_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                odd_in,
  input  logic [CS_W-1:0]     cs_n,
  output cpc_pkg::cpc_stage_t stage
);
  import cpc_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage <= CPC_STAGE_IDLE;
    end else begin
      stage.odd  <= odd_in;
      stage.qual <= ~(&cs_n);
    end
  end
endmodule

// File: rtl/cpc_err_stretch.sv
module cpc_err_stretch #(
  parameter int PULSE_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  output logic err_n
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_LEN);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (hit) begin
      remain <= LOAD;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign err_n = (remain == '0);
endmodule

// File: rtl/cmd_parity_check.sv
module cmd_parity_check #(
  parameter int ADDR_W    = 16,
  parameter int BANK_W    = 3,
  parameter int CS_W      = 4,
  parameter int PULSE_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ca_addr,
  input  logic [BANK_W-1:0] ca_bank,
  input  logic              ca_ras_n,
  input  logic              ca_cas_n,
  input  logic              ca_we_n,
  input  logic [CS_W-1:0]   cs_n,
  input  logic              par_in,
  output logic              err_n,
  output logic              cmd_drop
);
  import cpc_pkg::*;

  localparam int DATA_W = ADDR_W + BANK_W + 3;

  logic [DATA_W-1:0] word;
  logic              word_odd;
  cpc_stage_t        stage;
  logic              hit;

  // Only the command/address lines form the checked word (R1, R5).
  assign word = {ca_we_n, ca_cas_n, ca_ras_n, ca_bank, ca_addr};

  cpc_parity_fold #(.W(DATA_W)) u_fold (
    .bits (word),
    .odd  (word_odd)
  );

  cpc_capture #(.CS_W(CS_W)) u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .odd_in (word_odd),
    .cs_n   (cs_n),
    .stage  (stage)
  );

  // Late parity bit meets the captured command (R2, R3).
  assign hit = stage.qual & (stage.odd ^ par_in);

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_drop <= 1'b0;
    else        cmd_drop <= hit;
  end

  cpc_err_stretch #(.PULSE_LEN(PULSE_LEN)) u_stretch (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit),
    .err_n (err_n)
  );
endmodule

// File: rtl/cmd_parity_check_props.sv
module cmd_parity_check_props #(
  parameter int ADDR_W    = 16,
  parameter int BANK_W    = 3,
  parameter int CS_W      = 4,
  parameter int PULSE_LEN = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] ca_addr,
  input logic [BANK_W-1:0] ca_bank,
  input logic              ca_ras_n,
  input logic              ca_cas_n,
  input logic              ca_we_n,
  input logic [CS_W-1:0]   cs_n,
  input logic              par_in,
  input logic              err_n,
  input logic              cmd_drop
);
  localparam int DATA_W = ADDR_W + BANK_W + 3;
  localparam int AGE_W  = $clog2(PULSE_LEN + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(PULSE_LEN);

  logic [DATA_W-1:0] word;
  logic [1:0]        warm;
  logic [AGE_W-1:0]  since_q;
  logic [AGE_W-1:0]  age;

  assign word = {ca_we_n, ca_cas_n, ca_ras_n, ca_bank, ca_addr};

  always_ff @(posedge clk) begin
    if (!rst_n)         warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 since_q <= AGE_MAX;
    else if (cmd_drop)          since_q <= AGE_W'(1);
    else if (since_q < AGE_MAX) since_q <= since_q + 1'b1;
  end

  assign age = cmd_drop ? '0 : since_q;

  // R1 R2 R3: odd total on a qualified command, parity one edge late, gives a drop
  assert_odd_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && !(&$past(cs_n, 2)) && ((^$past(word, 2)) ^ $past(par_in)))
      |-> cmd_drop);

  // R1 R2: an even total never drops
  assert_even_passes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && !((^$past(word, 2)) ^ $past(par_in))) |-> !cmd_drop);

  // R4: deselected commands are ignored
  assert_deselect_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && (&$past(cs_n, 2))) |-> !cmd_drop);

  // R8: the first two cycles after reset carry no captured command
  assert_reset_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd2) |-> (!cmd_drop && err_n));

  // R6 R7: error flag accompanies every drop strobe
  assert_drop_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_drop |-> !err_n);

  // R7: error flag low exactly inside the stretch window, restarting on each drop
  assert_window_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (age < AGE_MAX) |-> !err_n);

  assert_window_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= AGE_MAX) |-> err_n);
endmodule

bind cmd_parity_check cmd_parity_check_props #(
  .ADDR_W    (ADDR_W),
  .BANK_W    (BANK_W),
  .CS_W      (CS_W),
  .PULSE_LEN (PULSE_LEN)
) u_props (
  .clk      (clk),
  .rst_n    (rst_n),
  .ca_addr  (ca_addr),
  .ca_bank  (ca_bank),
  .ca_ras_n (ca_ras_n),
  .ca_cas_n (ca_cas_n),
  .ca_we_n  (ca_we_n),
  .cs_n     (cs_n),
  .par_in   (par_in),
  .err_n    (err_n),
  .cmd_drop (cmd_drop)
);

// File: tb/cmd_parity_check_test.sv
`timescale 1ns/1ps
module cmd_parity_check_test;
  localparam int AW = 2;
  localparam int BW = 1;
  localparam int CW = 2;
  localparam int PL = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ca_addr = '0;
  logic [BW-1:0] ca_bank = '0;
  logic          ca_ras_n = 1'b1;
  logic          ca_cas_n = 1'b1;
  logic          ca_we_n = 1'b1;
  logic [CW-1:0] cs_n = '1;
  logic          par_in = 1'b0;
  logic          err_n;
  logic          cmd_drop;

  int vectors = 0;
  int miscompares = 0;

  // bench model state, built from the requirements
  logic m_qual = 1'b0;
  logic m_odd  = 1'b0;
  logic m_drop = 1'b0;
  int   m_cnt  = 0;

  always #4 clk = ~clk;

  cmd_parity_check #(.ADDR_W(AW), .BANK_W(BW), .CS_W(CW), .PULSE_LEN(PL)) uut (
    .clk (clk), .rst_n (rst_n), .ca_addr (ca_addr), .ca_bank (ca_bank),
    .ca_ras_n (ca_ras_n), .ca_cas_n (ca_cas_n), .ca_we_n (ca_we_n),
    .cs_n (cs_n), .par_in (par_in), .err_n (err_n), .cmd_drop (cmd_drop)
  );

  task automatic check(input string tag);
    logic exp_errn;
    exp_errn = (m_cnt == 0);
    vectors++;
    if (cmd_drop !== m_drop || err_n !== exp_errn) begin
      miscompares++;
      $display("FAIL %s: drop=%b err_n=%b expected drop=%b err_n=%b",
               tag, cmd_drop, err_n, m_drop, exp_errn);
    end
  endtask

  // Called at a falling edge: check outputs, drive the next command, advance the model.
  task automatic step(input logic [5:0] d, input logic [1:0] cs, input logic p,
                      input string tag);
    logic hit;
    check(tag);
    {ca_we_n, ca_cas_n, ca_ras_n, ca_bank, ca_addr} = d;
    cs_n   = cs;
    par_in = p;
    hit    = m_qual & (m_odd ^ p);
    m_drop = hit;
    if (hit)            m_cnt = PL;
    else if (m_cnt > 0) m_cnt = m_cnt - 1;
    m_qual = (cs != 2'b11);
    m_odd  = ^d;
    @(negedge clk);
  endtask

  task automatic model_reset();
    m_qual = 1'b0; m_odd = 1'b0; m_drop = 1'b0; m_cnt = 0;
  endtask

  initial begin
    #(200000 * 8);
    miscompares++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    string tag;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 reset state");
    rst_n = 1'b1;
    // R8: mismatch on the first edge after reset must not flag
    step(6'b000001, 2'b00, 1'b1, "R8 after reset");
    step(6'b000000, 2'b11, 1'b0, "R8 first paired edge");

    // Exhaustive sweep, two passes with opposite parity patterns (R1 R3 R4)
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 256; i++) begin
        logic p;
        p = (i[0] ^ i[3] ^ i[6]) ^ pass[0];
        if (!m_qual)            tag = "R4 deselected";
        else if (m_odd ^ p)     tag = "R1 R6 R7 error";
        else                    tag = "R1 R3 clean";
        step(i[5:0], i[7:6], p, tag);
      end
    end

    // R2: parity correct on the capture edge but wrong one edge later
    step(6'b000001, 2'b10, 1'b1, "R2 setup");
    step(6'b000000, 2'b11, 1'b0, "R2 late parity wrong");
    step(6'b000011, 2'b01, 1'b1, "R2 drop expected");
    step(6'b000000, 2'b11, 1'b0, "R2 even with odd par");

    // R5: same odd word under every qualifying chip-select pattern
    for (int c = 0; c < 3; c++) begin
      step(6'b010101, c[1:0], 1'b0, "R5 cs pattern");
      step(6'b000000, 2'b11, 1'b1, "R5 result");
    end

    // R9: run of consecutive bad commands, then recovery
    for (int k = 0; k < 4; k++) step(6'b000111, 2'b00, 1'b0, "R9 consecutive errors");
    for (int k = 0; k < 4; k++) step(6'b000000, 2'b11, 1'b0, "R9 R7 recovery");

    // R8: reset while an error pulse is active
    step(6'b000001, 2'b00, 1'b0, "R8 prime");
    step(6'b000000, 2'b11, 1'b0, "R8 error launched");
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    check("R8 reset during pulse");
    rst_n = 1'b1;
    step(6'b000000, 2'b00, 1'b1, "R8 release");
    step(6'b000000, 2'b11, 1'b0, "R8 pipeline cleared");
    step(6'b000000, 2'b11, 1'b0, "R8 final");
    check("R8 idle");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule